// File: doc/BRIEF.md
# Private Timer Interrupt Edge Router

This block sits between the per-CPU private timers and watchdogs and the interrupt controller. Each of these sources drives a level output. The block turns every low-to-high transition of those levels into a one-cycle "set pending" request for a private interrupt. Each request names the CPU it is meant for and the interrupt ID to raise.

There are `2*NUM_CPU` input lines. Line `2c` carries the timer of CPU `c` and line `2c+1` carries the watchdog of CPU `c`. The block keeps one stored previous level for each line and compares the current level against it, so a line that stays high raises nothing further.

Several lines can rise in the same cycle. Those rises are collected in a pending bitmap and issued one per cycle, lowest line index first. Storage of the pending state in the controller and prioritisation between interrupts belong to the controller, not to this block.

Top module: `tirq_edge_router`

## Requirements
- R1: While rst_ni is low, req_valid_o is 0 and every stored previous level is 0, so a line that is already high when reset releases produces one request after the first clock edge.
- R2: A line seen high at a clock edge with a stored low level produces a request with req_valid_o high for exactly one cycle, starting just after that edge when the queue is otherwise empty.
- R3: A line that stays high produces no request after its first one.
- R4: A falling line produces no request, and a later rise of the same line produces a new request.
- R5: req_cpu_o (2 bits) equals the line index shifted right by one.
- R6: req_id_o (5 bits) is 29 for even lines (timers) and 30 for odd lines (watchdogs).
- R7: Lines rising in the same cycle are issued on consecutive cycles in ascending line index order.
- R8: The stored previous level follows the input at every edge, even while earlier requests are still queued. A rise that is recorded while the queue is busy is still issued, even if the line drops before its turn.
- R9: With nothing pending and no rise, req_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_i | input | 2*NUM_CPU | Timer (even) and watchdog (odd) interrupt levels |
| req_valid_o | output | 1 | One-cycle set-pending request strobe |
| req_cpu_o | output | 2 | Target CPU of the request |
| req_id_o | output | 5 | Private interrupt ID of the request |

## Verification
A corrupted stored previous level shows up one cycle after the next clock edge. It appears either as a missing strobe for a genuine rise or as an extra strobe for a line that was already high. A corrupted pending bitmap shows up within at most 2*NUM_CPU cycles. It appears as a lost, duplicated or out-of-order request in the burst that follows a simultaneous rise, and a wrong CPU index or ID is visible in the same cycle as the strobe.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  localparam int unsigned CPU_W = 2;
  localparam int unsigned IRQ_W = 5;
  localparam logic [IRQ_W-1:0] TIMER_IRQ_ID = 5'd29;

  typedef struct packed {
    logic             valid;
    logic [CPU_W-1:0] cpu;
    logic [IRQ_W-1:0] id;
  } set_req_t;
endpackage

// File: rtl/tirq_edge_detect.sv
module tirq_edge_detect #(
  parameter int unsigned LINES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] level_i,
  output logic [LINES-1:0] rise_o
);
  logic [LINES-1:0] prev_q;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= level_i[g];
    end
    assign rise_o[g] = level_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/tirq_pend_arb.sv
module tirq_pend_arb #(
  parameter int unsigned LINES = 8,
  localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] rise_i,
  output logic             grant_vld_o,
  output logic [IDX_W-1:0] grant_idx_o,
  output logic [LINES-1:0] pend_o
);
  logic [LINES-1:0] pend_q, all_req, pend_d;

  assign all_req = pend_q | rise_i;

  // lowest index wins
  always_comb begin
    grant_idx_o = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (all_req[i]) grant_idx_o = IDX_W'(i);
    end
  end

  assign grant_vld_o = |all_req;

  always_comb begin
    pend_d = all_req;
    if (grant_vld_o) pend_d[grant_idx_o] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  p_queue_drains_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i == '0) |=> ($countones(pend_q) <= $past($countones(pend_q))));
endmodule

// File: rtl/tirq_edge_router.sv
module tirq_edge_router
  import tirq_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  localparam int unsigned LINES  = 2 * NUM_CPU,
  localparam int unsigned IDX_W  = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] level_i,
  output logic             req_valid_o,
  output logic [CPU_W-1:0] req_cpu_o,
  output logic [IRQ_W-1:0] req_id_o
);
  logic [LINES-1:0] rise;
  logic [LINES-1:0] pend;
  logic             grant_vld;
  logic [IDX_W-1:0] grant_idx;
  set_req_t         req_d, req_q;

  tirq_edge_detect #(.LINES(LINES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (level_i),
    .rise_o  (rise)
  );

  tirq_pend_arb #(.LINES(LINES)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (rise),
    .grant_vld_o (grant_vld),
    .grant_idx_o (grant_idx),
    .pend_o      (pend)
  );

  always_comb begin
    req_d.valid = grant_vld;
    req_d.cpu   = CPU_W'(grant_idx >> 1);
    req_d.id    = TIMER_IRQ_ID + IRQ_W'(grant_idx[0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_d;
  end

  assign req_valid_o = req_q.valid;
  assign req_cpu_o   = req_q.cpu;
  assign req_id_o    = req_q.id;

  p_rise_served_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> req_valid_o);
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rise == '0) && (pend == '0)) |=> !req_valid_o);
  p_cpu_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (int'(req_cpu_o) < NUM_CPU));
  p_id_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_id_o == 5'd29 || req_id_o == 5'd30));
endmodule

// File: tb/tirq_edge_router_tb.sv
module tirq_edge_router_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] lines = '0;
  logic       vld;
  logic [1:0] cpu;
  logic [4:0] id;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tirq_edge_router #(.NUM_CPU(4)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .level_i     (lines),
    .req_valid_o (vld),
    .req_cpu_o   (cpu),
    .req_id_o    (id)
  );

  task automatic chk(input logic ev, input int line, input string tag);
    logic [1:0] ec;
    logic [4:0] ei;
    ec = 2'(line >> 1);
    ei = 5'(29 + (line % 2));
    checks++;
    if (vld !== ev || (ev && (cpu !== ec || id !== ei))) begin
      errors++;
      $display("FAIL %s: got v=%0b cpu=%0d id=%0d exp v=%0b cpu=%0d id=%0d",
               tag, vld, cpu, id, ev, ec, ei);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic t_reset();
    lines = 8'h08;
    nxt();
    chk(1'b0, 0, "R1 valid low in reset");
    rst_n = 1'b1;
    nxt();
    chk(1'b1, 3, "R1 high line after reset");
    nxt();
    chk(1'b0, 0, "R3 no repeat after reset request");
    lines = '0;
    nxt(); nxt();
  endtask

  task automatic t_single();
    for (int i = 0; i < 8; i++) begin
      lines = 8'(1 << i);
      nxt();
      chk(1'b1, i, "R2 R5 R6 single rise");
      nxt();
      chk(1'b0, 0, "R2 one cycle pulse");
      nxt(); nxt();
      chk(1'b0, 0, "R3 steady high quiet");
      lines = '0;
      nxt();
      chk(1'b0, 0, "R4 fall quiet");
      nxt();
      chk(1'b0, 0, "R9 idle");
    end
  endtask

  task automatic t_rerise();
    lines = 8'h01;
    nxt();
    chk(1'b1, 0, "R4 first rise");
    lines = '0;
    nxt();
    chk(1'b0, 0, "R4 fall");
    lines = 8'h01;
    nxt();
    chk(1'b1, 0, "R4 re-rise");
    lines = '0;
    nxt();
    chk(1'b0, 0, "R9 idle after re-rise");
  endtask

  task automatic t_simul();
    lines = 8'b1010_0110;
    nxt(); chk(1'b1, 1, "R7 order 1st");
    nxt(); chk(1'b1, 2, "R7 order 2nd");
    nxt(); chk(1'b1, 5, "R7 order 3rd");
    nxt(); chk(1'b1, 7, "R7 order 4th");
    nxt(); chk(1'b0, 0, "R7 burst ends");
    lines = '0;
    nxt(); nxt();
  endtask

  task automatic t_busy_pulse();
    lines = 8'h07;
    nxt(); chk(1'b1, 0, "R8 busy first");
    lines = 8'h47;
    nxt(); chk(1'b1, 1, "R8 busy second");
    lines = 8'h07;
    nxt(); chk(1'b1, 2, "R8 busy third");
    nxt(); chk(1'b1, 6, "R8 short pulse kept");
    nxt(); chk(1'b0, 0, "R8 queue empty");
    lines = '0;
    nxt(); chk(1'b0, 0, "R9 final idle");
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_rerise();
    t_simul();
    t_busy_pulse();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule